// File: doc/BRIEF.md
# UART Receive Channel with Configurable Framing

This block is one asynchronous serial receive channel. It watches a single serial input line, finds start bits, samples each bit in the middle of its period, and places every finished character into the low byte of a 16-bit data register. The divisor that sets the bit rate sits in the upper bits of that same register. A small write port loads a configuration register, the divisor, and a clear register for the sticky error flags.

The configuration selects one of two clock-enable inputs as the channel's operation clock. It also selects line inversion, the order in which bits are assembled, 7 or 8 data bits and one of four parity modes, and it can mask the error interrupt. One stop bit is always checked. Each finished character raises a one-cycle transfer-end pulse. A framing, parity or overrun error sets a sticky flag and, when enabled, a one-cycle error-interrupt pulse.

Top module: `uart_rx_chan`

## Requirements
- R1: After synchronous reset, every output is 0: `rd_data`, `buf_full`, the three error flags and both interrupt pulses.
- R2: The operation clock is `clk_en_a` when config bit 0 is 0 and `clk_en_b` when it is 1. One bit lasts (divisor+1)*2 operation-clock ticks. A low level starts a start bit, and the start bit is accepted only if the line is still low (divisor+1) ticks later. A shorter low pulse produces no character.
- R3: Config bit 1 = 1 complements the line before start detection and sampling.
- R4: Config bit 2 = 0 assembles data MSB first. Bit 2 = 1 assembles it LSB first, so the first data bit received lands in bit 0.
- R5: Config bit 3 = 1 selects 8 data bits. Bit 3 = 0 selects 7 data bits, and bit 7 of the stored byte is then 0.
- R6: Config bits [5:4] set the parity mode. 00 means no parity bit. 01 means a parity bit is received but not checked. 10 means even parity is checked. 11 means odd parity is checked. A mismatch sets `err_parity`.
- R7: Each finished character produces a `irq_done` pulse that lasts exactly one clock cycle.
- R8: A stop bit sampled as 0 sets `err_frame`.
- R9: A finished character sets `buf_full`, and a cycle with `rd_en` high clears it. A character that finishes while `buf_full` is set, with no read in the same cycle, sets `err_overrun`. The new byte replaces the old one.
- R10: Config bit 6 = 1 makes `irq_err` pulse together with `irq_done` whenever that character raised any error. When bit 6 = 0, `irq_err` stays low, but the flags are still set.
- R11: Error flags are sticky. A write to address 2 clears `err_frame`, `err_parity` or `err_overrun` for each of `wr_data` bits 0, 1 or 2 that is set.
- R12: A write to address 0 loads the config from `wr_data[6:0]`. A write to address 1 loads the divisor from `wr_data[15:9]`. `rd_data` reads back as {divisor, 1'b0, received byte}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en_a | input | 1 | First operation-clock enable |
| clk_en_b | input | 1 | Second operation-clock enable |
| rxd_i | input | 1 | Serial receive line |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 config, 1 divisor, 2 clear |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Data register read strobe |
| rd_data | output | 16 | Divisor, padding bit and received byte |
| buf_full | output | 1 | Unread character present |
| err_frame | output | 1 | Sticky framing error |
| err_parity | output | 1 | Sticky parity error |
| err_overrun | output | 1 | Sticky overrun error |
| irq_done | output | 1 | Transfer-end pulse |
| irq_err | output | 1 | Error-interrupt pulse |

## Verification
A wrong bit counter or sample counter in the framer shows up at the ports within one character. Either the stored byte is shifted, or `irq_done` comes some ticks early or late, and a model that tracks every clock catches this on the first cycle that differs. A bad polarity, order or length setting shows up as a wrong byte at the very next transfer end. Broken status logic, such as a flag that is not sticky or a read that does not clear `buf_full`, shows up one clock after the event that should have changed it.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_SKIP = 2'b01,
        PAR_EVEN = 2'b10,
        PAR_ODD  = 2'b11
    } par_mode_e;

    // packed LSB last: clk_sel is bit 0, err_irq_en is bit 6
    typedef struct packed {
        logic      err_irq_en;
        par_mode_e par;
        logic      len8;
        logic      lsb_first;
        logic      invert;
        logic      clk_sel;
    } cfg_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic       done;
        logic [7:0] data;
        logic       ferr;
        logic       perr;
    } rx_result_t;

    localparam int unsigned CFG_W = $bits(cfg_t);
    localparam logic [1:0] ADDR_CFG = 2'd0;
    localparam logic [1:0] ADDR_DIV = 2'd1;
    localparam logic [1:0] ADDR_CLR = 2'd2;

    function automatic logic parity_bad(par_mode_e m, logic [7:0] d, logic p);
        case (m)
            PAR_EVEN: return ^{d, p};
            PAR_ODD:  return ~(^{d, p});
            default:  return 1'b0;
        endcase
    endfunction

    function automatic logic [7:0] finish_byte(logic [7:0] sh, logic lsb, logic len8);
        if (len8)
            return sh;
        else if (lsb)
            return {1'b0, sh[7:1]};
        else
            return {1'b0, sh[6:0]};
    endfunction

endpackage

// File: rtl/uart_rx_cfg_regs.sv
module uart_rx_cfg_regs
    import uart_rx_pkg::*;
#(
    parameter int DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [15:0]      wr_data,
    output cfg_t             cfg,
    output logic [DIV_W-1:0] div,
    output logic [2:0]       clr_mask
);
    logic unused_bits;
    assign unused_bits = ^wr_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
            div <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_CFG)
                cfg <= cfg_t'(wr_data[CFG_W-1:0]);
            if (wr_addr == ADDR_DIV)
                div <= wr_data[15 -: DIV_W];
        end
    end

    always_comb
        clr_mask = (wr_en && wr_addr == ADDR_CLR) ? wr_data[2:0] : 3'b000;
endmodule

// File: rtl/uart_rx_framer.sv
module uart_rx_framer
    import uart_rx_pkg::*;
#(
    parameter int DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             line,
    input  logic             lsb_first,
    input  logic             len8,
    input  par_mode_e        par,
    input  logic [DIV_W-1:0] div,
    output rx_result_t       res
);
    localparam int CNT_W = DIV_W + 1;

    rx_state_e        st;
    logic [CNT_W-1:0] cnt;
    logic [2:0]       nb;
    logic [7:0]       sh;
    logic             pbit;
    logic             half_hit, full_hit;
    logic [2:0]       last_nb;
    logic [7:0]       sh_next, byte_fin;

    always_comb begin
        half_hit = (cnt == {1'b0, div});
        full_hit = (cnt == {div, 1'b1});
        last_nb  = len8 ? 3'd7 : 3'd6;
        sh_next  = lsb_first ? {line, sh[7:1]} : {sh[6:0], line};
        byte_fin = finish_byte(sh, lsb_first, len8);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            cnt  <= '0;
            nb   <= '0;
            sh   <= '0;
            pbit <= 1'b0;
            res  <= '0;
        end else begin
            res.done <= 1'b0;
            if (tick) begin
                case (st)
                    ST_IDLE: if (!line) begin
                        st  <= ST_START;
                        cnt <= '0;
                    end
                    ST_START: if (half_hit) begin
                        cnt <= '0;
                        nb  <= '0;
                        sh  <= '0;
                        st  <= line ? ST_IDLE : ST_DATA;
                    end else cnt <= cnt + 1'b1;
                    ST_DATA: if (full_hit) begin
                        cnt <= '0;
                        sh  <= sh_next;
                        nb  <= nb + 1'b1;
                        if (nb == last_nb)
                            st <= (par == PAR_NONE) ? ST_STOP : ST_PAR;
                    end else cnt <= cnt + 1'b1;
                    ST_PAR: if (full_hit) begin
                        cnt  <= '0;
                        pbit <= line;
                        st   <= ST_STOP;
                    end else cnt <= cnt + 1'b1;
                    ST_STOP: if (full_hit) begin
                        cnt      <= '0;
                        st       <= ST_IDLE;
                        res.done <= 1'b1;
                        res.data <= byte_fin;
                        res.ferr <= ~line;
                        res.perr <= parity_bad(par, byte_fin, pbit);
                    end else cnt <= cnt + 1'b1;
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
    import uart_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  rx_result_t res,
    input  logic       rd_en,
    input  logic [2:0] clr_mask,
    input  logic       err_en,
    output logic [7:0] rx_byte,
    output logic       buf_full,
    output logic       err_frame,
    output logic       err_parity,
    output logic       err_overrun,
    output logic       irq_done,
    output logic       irq_err
);
    logic new_ovr;

    always_comb new_ovr = res.done && buf_full && !rd_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_byte     <= '0;
            buf_full    <= 1'b0;
            err_frame   <= 1'b0;
            err_parity  <= 1'b0;
            err_overrun <= 1'b0;
            irq_done    <= 1'b0;
            irq_err     <= 1'b0;
        end else begin
            err_frame   <= (err_frame   & ~clr_mask[0]) | (res.done & res.ferr);
            err_parity  <= (err_parity  & ~clr_mask[1]) | (res.done & res.perr);
            err_overrun <= (err_overrun & ~clr_mask[2]) | new_ovr;
            irq_done    <= res.done;
            irq_err     <= res.done & err_en & (res.ferr | res.perr | new_ovr);
            if (res.done) begin
                rx_byte  <= res.data;
                buf_full <= 1'b1;
            end else if (rd_en) begin
                buf_full <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/uart_rx_chan.sv
module uart_rx_chan
    import uart_rx_pkg::*;
#(
    parameter int DIV_W       = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        clk_en_a,
    input  logic        clk_en_b,
    input  logic        rxd_i,
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [15:0] wr_data,
    input  logic        rd_en,
    output logic [15:0] rd_data,
    output logic        buf_full,
    output logic        err_frame,
    output logic        err_parity,
    output logic        err_overrun,
    output logic        irq_done,
    output logic        irq_err
);
    localparam int PAD_W = 8 - DIV_W;

    cfg_t                   cfg;
    logic [DIV_W-1:0]       div;
    logic [2:0]             clr_mask;
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   line, tick;
    rx_result_t             res;
    logic [7:0]             rx_byte;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], rxd_i};
    end

    always_comb begin
        line = sync_q[SYNC_STAGES-1] ^ cfg.invert;
        tick = cfg.clk_sel ? clk_en_b : clk_en_a;
    end

    uart_rx_cfg_regs #(.DIV_W(DIV_W)) u_cfg (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cfg(cfg), .div(div), .clr_mask(clr_mask)
    );

    uart_rx_framer #(.DIV_W(DIV_W)) u_framer (
        .clk(clk), .rst(rst), .tick(tick), .line(line),
        .lsb_first(cfg.lsb_first), .len8(cfg.len8), .par(cfg.par),
        .div(div), .res(res)
    );

    uart_rx_status u_status (
        .clk(clk), .rst(rst), .res(res), .rd_en(rd_en), .clr_mask(clr_mask),
        .err_en(cfg.err_irq_en), .rx_byte(rx_byte), .buf_full(buf_full),
        .err_frame(err_frame), .err_parity(err_parity),
        .err_overrun(err_overrun), .irq_done(irq_done), .irq_err(irq_err)
    );

    assign rd_data = {div, {PAD_W{1'b0}}, rx_byte};
endmodule

// File: rtl/uart_rx_chan_chk.sv
module uart_rx_chan_chk (
    input logic clk,
    input logic rst,
    input logic irq_done,
    input logic irq_err,
    input logic buf_full,
    input logic err_frame,
    input logic err_overrun,
    input logic rd_en,
    input logic clr_ovr
);
    // R7: transfer-end is a single-cycle pulse
    p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
        irq_done |=> !irq_done);

    // R10: error interrupt only alongside a transfer end
    p_err_with_done_r10: assert property (@(posedge clk) disable iff (rst)
        irq_err |-> irq_done);

    // R9: a finished character leaves the buffer full
    p_full_on_done_r9: assert property (@(posedge clk) disable iff (rst)
        irq_done |-> buf_full);

    // R9: a read with no completing character empties the buffer
    p_rd_clear_r9: assert property (@(posedge clk) disable iff (rst)
        $past(rd_en) && !irq_done |-> !buf_full);

    // R8: framing flag only rises at a transfer end
    p_frame_rise_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(err_frame) |-> irq_done);

    // R11: overrun flag holds until cleared
    p_ovr_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        $past(err_overrun) && !$past(clr_ovr) |-> err_overrun);
endmodule

bind uart_rx_chan uart_rx_chan_chk chk_i (
    .clk(clk), .rst(rst), .irq_done(irq_done), .irq_err(irq_err),
    .buf_full(buf_full), .err_frame(err_frame), .err_overrun(err_overrun),
    .rd_en(rd_en), .clr_ovr(wr_en && wr_addr == 2'd2 && wr_data[2])
);

// File: tb/uart_rx_chan_tb_top.sv
`timescale 1ns/1ps
module uart_rx_chan_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ena = 1'b1, enb = 1'b0, run = 1'b1;
    logic        rxd = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [15:0] rd_data;
    logic        buf_full, err_frame, err_parity, err_overrun, irq_done, irq_err;

    int checks = 0, errors = 0;
    int cnt_done = 0, cnt_err = 0;
    bit finished = 0;

    // model configuration (mirrors what the bench wrote)
    int m_sel = 0, m_inv = 0, m_lsb = 0, m_len8 = 0, m_par = 0, m_erren = 0, m_div = 0;
    // model state
    int m_s1 = 1, m_s2 = 1, m_state = 0, m_t = 0, m_nb = 0, m_pbit = 0;
    int m_bits[8];
    int p_valid = 0, p_byte = 0, p_fe = 0, p_pe = 0;
    int e_done = 0, e_err = 0, e_full = 0, e_buf = 0, e_fe = 0, e_pe = 0, e_ov = 0;

    uart_rx_chan dut_i (
        .clk(clk), .rst(rst), .clk_en_a(ena), .clk_en_b(enb), .rxd_i(rxd),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .buf_full(buf_full), .err_frame(err_frame),
        .err_parity(err_parity), .err_overrun(err_overrun),
        .irq_done(irq_done), .irq_err(irq_err)
    );

    always #10 clk = ~clk;

    always @(negedge clk) begin
        ena <= run;
        enb <= run ? ~enb : 1'b0;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference, advanced on every rising edge
    always @(posedge clk) begin
        int line, tick, clr, nov, n, ones, b;
        if (rst) begin
            m_s1 = 1; m_s2 = 1; m_state = 0; m_t = 0; m_nb = 0; m_pbit = 0;
            p_valid = 0; e_done = 0; e_err = 0; e_full = 0; e_buf = 0;
            e_fe = 0; e_pe = 0; e_ov = 0;
        end else begin
            clr = (wr_en && wr_addr == 2'd2) ? int'(wr_data[2:0]) : 0;
            if (clr & 1) e_fe = 0;
            if (clr & 2) e_pe = 0;
            if (clr & 4) e_ov = 0;
            if (p_valid != 0) begin
                nov = (e_full != 0 && !rd_en) ? 1 : 0;
                e_buf = p_byte; e_full = 1;
                if (p_fe != 0) e_fe = 1;
                if (p_pe != 0) e_pe = 1;
                if (nov != 0) e_ov = 1;
                e_done = 1;
                e_err = (m_erren != 0 && (p_fe != 0 || p_pe != 0 || nov != 0)) ? 1 : 0;
            end else begin
                e_done = 0; e_err = 0;
                if (rd_en) e_full = 0;
            end
            p_valid = 0;
            line = m_s2 ^ m_inv;
            tick = (m_sel != 0) ? int'(enb) : int'(ena);
            n = (m_len8 != 0) ? 8 : 7;
            if (tick != 0) begin
                if (m_state == 0) begin
                    if (line == 0) begin m_state = 1; m_t = 0; end
                end else if (m_state == 1) begin
                    if (m_t == m_div) begin
                        m_t = 0; m_nb = 0;
                        m_state = (line == 0) ? 2 : 0;
                    end else m_t++;
                end else if (m_t == 2 * m_div + 1) begin
                    m_t = 0;
                    if (m_state == 2) begin
                        m_bits[m_nb] = line; m_nb++;
                        if (m_nb == n) m_state = (m_par != 0) ? 3 : 4;
                    end else if (m_state == 3) begin
                        m_pbit = line; m_state = 4;
                    end else begin
                        p_byte = 0; ones = 0;
                        for (int i = 0; i < n; i++) begin
                            b = (m_lsb != 0) ? i : n - 1 - i;
                            p_byte += m_bits[i] << b;
                            ones += m_bits[i];
                        end
                        p_pe = ((m_par == 2 && (ones + m_pbit) % 2 != 0) ||
                                (m_par == 3 && (ones + m_pbit) % 2 == 0)) ? 1 : 0;
                        p_fe = (line == 0) ? 1 : 0;
                        p_valid = 1; m_state = 0;
                    end
                end else m_t++;
            end
            m_s2 = m_s1; m_s1 = rxd;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (irq_done) cnt_done++;
            if (irq_err)  cnt_err++;
            check("R7 irq_done",     irq_done,     e_done);
            check("R10 irq_err",     irq_err,      e_err);
            check("R9 buf_full",     buf_full,     e_full);
            check("R8 err_frame",    err_frame,    e_fe);
            check("R6 err_parity",   err_parity,   e_pe);
            check("R9 err_overrun",  err_overrun,  e_ov);
            check("R4 rd_data byte", rd_data[7:0], e_buf);
        end
    end

    task automatic wr(input int a, input int d);
        wr_en = 1'b1; wr_addr = 2'(a); wr_data = 16'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_cfg(input int sel, inv, lsb, len8, par, erren);
        m_sel = sel; m_inv = inv; m_lsb = lsb; m_len8 = len8; m_par = par; m_erren = erren;
        wr(0, sel | (inv << 1) | (lsb << 2) | (len8 << 3) | (par << 4) | (erren << 6));
    endtask

    task automatic set_div(input int d);
        m_div = d;
        wr(1, d << 9);
    endtask

    task automatic read_buf();
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic send_char(input int val, input int stopv, input int flip_par);
        int n, per, ones, p;
        int seq[12];
        int k;
        n = (m_len8 != 0) ? 8 : 7;
        per = 2 * (m_div + 1) * ((m_sel != 0) ? 2 : 1);
        k = 0;
        seq[k++] = 0;
        ones = 0;
        for (int i = 0; i < n; i++) begin
            seq[k] = (m_lsb != 0) ? (val >> i) & 1 : (val >> (n - 1 - i)) & 1;
            ones += seq[k];
            k++;
        end
        if (m_par != 0) begin
            p = (m_par == 3) ? 1 - (ones % 2) : ones % 2;
            seq[k++] = p ^ flip_par;
        end
        seq[k++] = stopv;
        for (int i = 0; i < k; i++) begin
            rxd = 1'(seq[i] ^ m_inv);
            repeat (per) @(negedge clk);
        end
        rxd = 1'(1 ^ m_inv);
        repeat (3 * per) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int d0, e0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check("R1 rd_data", rd_data, 0);
        check("R1 flags", {buf_full, err_frame, err_parity, err_overrun, irq_done, irq_err}, 0);

        // R12: divisor in upper bits
        set_div(3);
        @(negedge clk);
        check("R12 divisor field", rd_data[15:9], 3);
        check("R12 pad bit", rd_data[8], 0);

        // R4: 8-bit LSB first
        set_cfg(0, 0, 1, 1, 0, 1);
        send_char(8'hA5, 1, 0);
        check("R4 lsb byte", rd_data[7:0], 8'hA5);
        check("R9 full", buf_full, 1);
        read_buf();
        check("R9 read clears full", buf_full, 0);

        // R4: 8-bit MSB first
        set_cfg(0, 0, 0, 1, 0, 1);
        d0 = cnt_done;
        send_char(8'h3C, 1, 0);
        check("R4 msb byte", rd_data[7:0], 8'h3C);
        check("R7 one pulse", cnt_done - d0, 1);
        read_buf();

        // R5: 7-bit modes
        set_cfg(0, 0, 1, 0, 0, 1);
        send_char(8'hD3, 1, 0);
        check("R5 7-bit lsb", rd_data[7:0], 8'h53);
        read_buf();
        set_cfg(0, 0, 0, 0, 0, 1);
        send_char(8'h6A, 1, 0);
        check("R5 7-bit msb", rd_data[7:0], 8'h6A);
        read_buf();

        // R6: even parity good and bad
        set_cfg(0, 0, 1, 1, 2, 1);
        send_char(8'h5B, 1, 0);
        check("R6 even ok", err_parity, 0);
        read_buf();
        e0 = cnt_err;
        send_char(8'h5B, 1, 1);
        check("R6 even bad", err_parity, 1);
        check("R10 irq_err on parity", cnt_err - e0, 1);
        read_buf();
        // R11: clear parity
        wr(2, 2);
        check("R11 parity cleared", err_parity, 0);

        // R6: odd parity
        set_cfg(0, 0, 0, 1, 3, 1);
        send_char(8'h17, 1, 0);
        check("R6 odd ok", err_parity, 0);
        read_buf();
        send_char(8'h17, 1, 1);
        check("R6 odd bad", err_parity, 1);
        read_buf();
        wr(2, 2);

        // R6: parity received, not checked
        set_cfg(0, 0, 1, 1, 1, 1);
        send_char(8'hC4, 1, 1);
        check("R6 skip no error", err_parity, 0);
        check("R6 skip byte", rd_data[7:0], 8'hC4);
        read_buf();

        // R8: framing error
        set_cfg(0, 0, 1, 1, 0, 1);
        send_char(8'h99, 0, 0);
        check("R8 frame flag", err_frame, 1);
        read_buf();
        wr(2, 1);
        check("R11 frame cleared", err_frame, 0);

        // R10: masked error interrupt
        set_cfg(0, 0, 1, 1, 0, 0);
        e0 = cnt_err;
        send_char(8'h42, 0, 0);
        check("R10 masked irq", cnt_err - e0, 0);
        check("R10 flag still set", err_frame, 1);
        read_buf();
        wr(2, 1);

        // R9: overrun
        set_cfg(0, 0, 1, 1, 0, 1);
        send_char(8'h11, 1, 0);
        send_char(8'h22, 1, 0);
        check("R9 overrun flag", err_overrun, 1);
        check("R9 newest byte", rd_data[7:0], 8'h22);
        read_buf();
        wr(2, 4);
        check("R11 overrun cleared", err_overrun, 0);

        // R2: short low pulse rejected
        d0 = cnt_done;
        rxd = 1'b0;
        repeat (2) @(negedge clk);
        rxd = 1'b1;
        repeat (40) @(negedge clk);
        check("R2 glitch rejected", cnt_done - d0, 0);
        check("R2 glitch no data", buf_full, 0);

        // R2: second clock enable and another divisor
        set_cfg(1, 0, 1, 1, 0, 1);
        send_char(8'h81, 1, 0);
        check("R2 clk_sel b", rd_data[7:0], 8'h81);
        read_buf();
        set_cfg(0, 0, 1, 1, 0, 1);
        set_div(1);
        send_char(8'hE7, 1, 0);
        check("R2 divisor 1", rd_data[7:0], 8'hE7);
        check("R12 divisor 1", rd_data[15:9], 1);
        read_buf();

        // R3: inverted line, switched with ticks halted
        run = 1'b0;
        repeat (3) @(negedge clk);
        rxd = 1'b0;
        set_cfg(0, 1, 1, 1, 0, 1);
        repeat (4) @(negedge clk);
        run = 1'b1;
        repeat (2) @(negedge clk);
        send_char(8'h4E, 1, 0);
        check("R3 inverted byte", rd_data[7:0], 8'h4E);
        check("R3 no frame err", err_frame, 0);
        read_buf();

        repeat (5) @(negedge clk);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule